// File: doc/BRIEF.md
# SIMD Lane Register File and ALU

This block is one lane of a lock-step SIMD array. Every lane receives the same decoded operation each cycle and applies it to its own 32 x 32-bit register file through a 32-bit ALU. The lane can also load a register from its local-store word, load a register from a random word, and conditionally copy one register into another. A flag held in a third register decides whether that copy happens.

Two combinational read ports expose register contents to the neighbouring local-store and address logic. Writes are synchronous. An operation is qualified by `op_valid`. Operations arrive in lock-step with the other lanes, so there is no ready signal and no back-pressure. A valid operation is consumed in the cycle it is presented, and the result is written on the next rising clock edge.

Top module: `lane_unit`

## Requirements
- R1: While `rst_n` is low, every register is cleared, so after reset all 32 registers read as zero on both read ports.
- R2: Op codes add=1, sub=2 and mul=3 write R[r3] with R[r1]+R[r2], R[r1]-R[r2] and the low 32 bits of R[r1]*R[r2], all wrapping modulo 2^32.
- R3: Op codes and=4, or=5 and xor=6 write R[r3] with the bitwise AND, OR and XOR of R[r1] and R[r2].
- R4: Op codes lt=7 and le=8 compare R[r1] with R[r2] as signed two's-complement values, and eq=9 tests equality. Each writes exactly 1 when the test holds and 0 when it does not.
- R5: Op code addi=10 writes R[r3] with R[r1] plus the 14-bit immediate sign-extended from bit 13, so immediate 0x3FFF adds -1.
- R6: Op code ashr=11 writes R[r3] with R[r1] shifted right arithmetically by immediate bits [4:0]. Immediate bits [13:5] are ignored.
- R7: Op code mvt=12 writes R[r1] with R[r2] when R[r3] is nonzero and leaves every register unchanged otherwise. While mvt is on `op_code`, read port A shows R[r3].
- R8: Op code ldr=14 writes R[r3] with `ls_word`, and op code rnd=13 writes R[r3] with `rnd_word`.
- R9: When `op_valid` is low, or the op code is 0 or any value above 14, no register changes.
- R10: Read port A shows R[r1] (R[r3] for mvt) and port B shows R[r2], both combinationally. A write becomes visible only after the rising edge that performs it. Register 0 is an ordinary register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies the operation on this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| r1_idx | input | 5 | First source / mvt destination index |
| r2_idx | input | 5 | Second source index |
| r3_idx | input | 5 | Destination / mvt condition index |
| imm | input | 14 | Signed immediate, shift count in bits [4:0] |
| ls_word | input | 32 | This lane's local-store word for ldr |
| rnd_word | input | 32 | Random word for rnd |
| rd_a_data | output | 32 | Read port A: R[r1], or R[r3] during mvt |
| rd_b_data | output | 32 | Read port B: R[r2] |

## Verification
The read ports are combinational, so their expected value is checked in the same cycle the indices are applied, a moment after the inputs change and before the next rising edge. A write issued in cycle N is expected on the ports only from cycle N+1. The bench therefore compares the ports against its model state as it stood before the current operation, and updates the model only after that comparison. Directed cases write a register in one cycle and probe it in the next with `op_valid` low. One case reads a register in the same cycle that it is being rewritten, to confirm the old value is still shown.

// File: rtl/lane_pkg.sv
package lane_pkg;
  parameter int unsigned LANE_XLEN  = 32;
  parameter int unsigned LANE_NREG  = 32;
  parameter int unsigned LANE_IMM_W = 14;
  parameter int unsigned LANE_OPC_W = 5;

  typedef enum logic [LANE_OPC_W-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_MUL  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_LT   = 5'd7,
    OP_LE   = 5'd8,
    OP_EQ   = 5'd9,
    OP_ADDI = 5'd10,
    OP_ASHR = 5'd11,
    OP_MVT  = 5'd12,
    OP_RND  = 5'd13,
    OP_LDR  = 5'd14
  } lane_op_e;

  typedef enum logic [1:0] {
    WSEL_ALU,
    WSEL_PORTB,
    WSEL_LS,
    WSEL_RND
  } wr_sel_e;
endpackage

// File: rtl/lane_regfile.sv
module lane_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra_addr,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data
);
  logic [XLEN-1:0] mem [NREG];

  // one storage row per register, each with its own write strobe
  for (genvar g = 0; g < NREG; g++) begin : g_row
    logic row_we;
    assign row_we = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      mem[g] <= '0;
      else if (row_we) mem[g] <= wdata;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 14,
  localparam int unsigned SH_W = $clog2(XLEN)
) (
  input  lane_op_e         op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  y
);
  logic [XLEN-1:0] imm_ext;
  logic [SH_W-1:0] shamt;
  logic            lt_s, le_s, eq_u;

  assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign shamt   = imm[SH_W-1:0];
  assign lt_s    = $signed(a) <  $signed(b);
  assign le_s    = $signed(a) <= $signed(b);
  assign eq_u    = (a == b);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_LT:   y = {{(XLEN-1){1'b0}}, lt_s};
      OP_LE:   y = {{(XLEN-1){1'b0}}, le_s};
      OP_EQ:   y = {{(XLEN-1){1'b0}}, eq_u};
      OP_ADDI: y = a + imm_ext;
      OP_ASHR: y = $unsigned($signed(a) >>> shamt);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/lane_decode.sv
module lane_decode
  import lane_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic            op_valid,
  input  lane_op_e        op,
  input  logic [AW-1:0]   r1_idx,
  input  logic [AW-1:0]   r3_idx,
  input  logic            cond_nz,
  output logic [AW-1:0]   ra_addr,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output wr_sel_e         wr_sel
);
  logic is_mvt;
  assign is_mvt  = (op == OP_MVT);
  // during mvt port A carries the condition register
  assign ra_addr = is_mvt ? r3_idx : r1_idx;
  assign wr_addr = is_mvt ? r1_idx : r3_idx;

  always_comb begin
    wr_en  = 1'b0;
    wr_sel = WSEL_ALU;
    unique case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR,
      OP_LT, OP_LE, OP_EQ, OP_ADDI, OP_ASHR: wr_en = op_valid;
      OP_MVT: begin
        wr_en  = op_valid && cond_nz;
        wr_sel = WSEL_PORTB;
      end
      OP_RND: begin
        wr_en  = op_valid;
        wr_sel = WSEL_RND;
      end
      OP_LDR: begin
        wr_en  = op_valid;
        wr_sel = WSEL_LS;
      end
      default: wr_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/lane_unit.sv
module lane_unit
  import lane_pkg::*;
#(
  parameter int unsigned XLEN  = LANE_XLEN,
  parameter int unsigned NREG  = LANE_NREG,
  parameter int unsigned IMM_W = LANE_IMM_W,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [LANE_OPC_W-1:0] op_code,
  input  logic [AW-1:0]         r1_idx,
  input  logic [AW-1:0]         r2_idx,
  input  logic [AW-1:0]         r3_idx,
  input  logic [IMM_W-1:0]      imm,
  input  logic [XLEN-1:0]       ls_word,
  input  logic [XLEN-1:0]       rnd_word,
  output logic [XLEN-1:0]       rd_a_data,
  output logic [XLEN-1:0]       rd_b_data
);
  lane_op_e        op;
  logic [AW-1:0]   ra_addr;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  wr_sel_e         wr_sel;
  logic [XLEN-1:0] alu_y;
  logic [XLEN-1:0] wr_data;
  logic            cond_nz;

  assign op      = lane_op_e'(op_code);
  assign cond_nz = |rd_a_data;

  lane_decode #(.AW(AW)) u_dec (
    .op_valid (op_valid),
    .op       (op),
    .r1_idx   (r1_idx),
    .r3_idx   (r3_idx),
    .cond_nz  (cond_nz),
    .ra_addr  (ra_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_sel   (wr_sel)
  );

  lane_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
    .op  (op),
    .a   (rd_a_data),
    .b   (rd_b_data),
    .imm (imm),
    .y   (alu_y)
  );

  always_comb begin
    unique case (wr_sel)
      WSEL_PORTB: wr_data = rd_b_data;
      WSEL_LS:    wr_data = ls_word;
      WSEL_RND:   wr_data = rnd_word;
      default:    wr_data = alu_y;
    endcase
  end

  lane_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .ra_addr (ra_addr),
    .rb_addr (r2_idx),
    .ra_data (rd_a_data),
    .rb_data (rd_b_data)
  );
endmodule

// File: rtl/lane_unit_chk.sv
module lane_unit_chk
  import lane_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_valid,
  input logic [LANE_OPC_W-1:0] op_code,
  input logic [AW-1:0]         r1_idx,
  input logic [AW-1:0]         r3_idx,
  input logic [XLEN-1:0]       ls_word,
  input logic [XLEN-1:0]       rd_a_data,
  input logic                  wr_en
);
  logic past_noop;
  assign past_noop = !op_valid || (op_code == OP_NOP) || (op_code > OP_LDR);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(past_noop) && $stable(op_code) && $stable(r1_idx) && $stable(r3_idx))
      |-> $stable(rd_a_data)); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    past_noop |-> !wr_en); // R9

  AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid && (op_code >= OP_LT) && (op_code <= OP_EQ))
      && (op_code != OP_MVT) && (r1_idx == $past(r3_idx)))
      |-> (rd_a_data[XLEN-1:1] == '0)); // R4

  AST_MVT_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_MVT) && (rd_a_data == '0)) |-> !wr_en); // R7

  AST_LDR_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_valid && (op_code == OP_LDR))
      && (op_code != OP_MVT) && (r1_idx == $past(r3_idx)))
      |-> (rd_a_data == $past(ls_word))); // R8
endmodule

bind lane_unit lane_unit_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .r1_idx    (r1_idx),
  .r3_idx    (r3_idx),
  .ls_word   (ls_word),
  .rd_a_data (rd_a_data),
  .wr_en     (wr_en)
);

// File: tb/lane_unit_tb.sv
module lane_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [4:0]  r1_idx = '0, r2_idx = '0, r3_idx = '0;
  logic [13:0] imm = '0;
  logic [31:0] ls_word = '0, rnd_word = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .r1_idx(r1_idx), .r2_idx(r2_idx), .r3_idx(r3_idx), .imm(imm),
    .ls_word(ls_word), .rnd_word(rnd_word),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference result from the requirement list
  function automatic logic [31:0] ref_alu(int op, logic [31:0] a, logic [31:0] b, logic [13:0] im);
    logic [31:0] se;
    se = {{18{im[13]}}, im};
    case (op)
      1: return a + b;
      2: return a - b;
      3: return a * b;
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      7: return ($signed(a) <  $signed(b)) ? 32'd1 : 32'd0;
      8: return ($signed(a) <= $signed(b)) ? 32'd1 : 32'd0;
      9: return (a == b) ? 32'd1 : 32'd0;
      10: return a + se;
      11: return $unsigned($signed(a) >>> im[4:0]);
      default: return 32'd0;
    endcase
  endfunction

  // drive one operation, check ports against pre-edge model, then update model
  task automatic issue(input bit v, input int op, input int a1, input int a2, input int a3,
                       input logic [13:0] im, input logic [31:0] lsw, input logic [31:0] rw);
    int pa;
    @(negedge clk);
    op_valid = v; op_code = op[4:0];
    r1_idx = a1[4:0]; r2_idx = a2[4:0]; r3_idx = a3[4:0];
    imm = im; ls_word = lsw; rnd_word = rw;
    #1;
    pa = (op == 12) ? a3 : a1;
    check(rd_a_data, model[pa], "R10 port A");
    check(rd_b_data, model[a2], "R10 port B");
    if (v) begin
      if (op >= 1 && op <= 11) model[a3] = ref_alu(op, model[a1], model[a2], im);
      else if (op == 12) begin if (model[a3] != 0) model[a1] = model[a2]; end
      else if (op == 13) model[a3] = rw;
      else if (op == 14) model[a3] = lsw;
    end
  endtask

  task automatic expect_reg(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    op_valid = 1'b0; op_code = '0;
    r1_idx = idx[4:0]; r2_idx = idx[4:0];
    #1;
    check(rd_a_data, exp, tag);
    check(rd_b_data, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 32; i++) expect_reg(i, 32'd0, "R1 reset");

    issue(1, 14, 0, 0, 5, 0, 32'h12345678, 0); expect_reg(5, 32'h12345678, "R8 ldr");
    issue(1, 13, 0, 0, 6, 0, 0, 32'hCAFEF00D); expect_reg(6, 32'hCAFEF00D, "R8 rnd");

    issue(1, 14, 0, 0, 1, 0, 32'hFFFFFFFF, 0);
    issue(1, 14, 0, 0, 2, 0, 32'd2, 0);
    issue(1, 14, 0, 0, 3, 0, 32'h00010000, 0);
    issue(1, 14, 0, 0, 4, 0, 32'h80000000, 0);
    issue(1, 14, 0, 0, 7, 0, 32'd1, 0);

    issue(1, 1, 1, 2, 8, 0, 0, 0);  expect_reg(8,  32'd1, "R2 add wrap");
    issue(1, 2, 2, 1, 9, 0, 0, 0);  expect_reg(9,  32'd3, "R2 sub");
    issue(1, 3, 3, 3, 10, 0, 0, 0); expect_reg(10, 32'd0, "R2 mul low bits");
    issue(1, 3, 1, 2, 11, 0, 0, 0); expect_reg(11, 32'hFFFFFFFE, "R2 mul neg");

    issue(1, 4, 1, 3, 12, 0, 0, 0); expect_reg(12, 32'h00010000, "R3 and");
    issue(1, 5, 2, 4, 13, 0, 0, 0); expect_reg(13, 32'h80000002, "R3 or");
    issue(1, 6, 1, 3, 14, 0, 0, 0); expect_reg(14, 32'hFFFEFFFF, "R3 xor");

    issue(1, 7, 1, 7, 15, 0, 0, 0); expect_reg(15, 32'd1, "R4 lt signed");
    issue(1, 7, 7, 1, 16, 0, 0, 0); expect_reg(16, 32'd0, "R4 lt false");
    issue(1, 8, 2, 2, 17, 0, 0, 0); expect_reg(17, 32'd1, "R4 le equal");
    issue(1, 8, 4, 1, 18, 0, 0, 0); expect_reg(18, 32'd1, "R4 le min");
    issue(1, 9, 2, 7, 19, 0, 0, 0); expect_reg(19, 32'd0, "R4 eq false");
    issue(1, 9, 1, 1, 20, 0, 0, 0); expect_reg(20, 32'd1, "R4 eq true");

    issue(1, 10, 0, 0, 21, 14'h3FFF, 0, 0); expect_reg(21, 32'hFFFFFFFF, "R5 addi -1");
    issue(1, 10, 2, 0, 22, 14'h1FFF, 0, 0); expect_reg(22, 32'h00002001, "R5 addi max");
    issue(1, 10, 2, 0, 23, 14'h2000, 0, 0); expect_reg(23, 32'hFFFFE002, "R5 addi min");

    issue(1, 11, 4, 0, 24, 14'h0024, 0, 0); expect_reg(24, 32'hF8000000, "R6 ashr high bits ignored");
    issue(1, 11, 3, 0, 25, 14'd16, 0, 0);   expect_reg(25, 32'd1, "R6 ashr positive");
    issue(1, 11, 1, 0, 26, 14'd31, 0, 0);   expect_reg(26, 32'hFFFFFFFF, "R6 ashr 31");

    issue(1, 12, 27, 2, 0, 0, 0, 0); expect_reg(27, 32'd0, "R7 mvt false");
    issue(1, 12, 27, 2, 7, 0, 0, 0); expect_reg(27, 32'd2, "R7 mvt true");

    issue(0, 1, 1, 2, 28, 0, 0, 0);           expect_reg(28, 32'd0, "R9 invalid");
    issue(1, 25, 1, 2, 28, 14'h3FFF, 32'd9, 32'd9); expect_reg(28, 32'd0, "R9 unused code");
    issue(1, 0, 1, 2, 28, 0, 32'd9, 32'd9);   expect_reg(28, 32'd0, "R9 nop");

    issue(1, 14, 0, 0, 29, 0, 32'd5, 0); expect_reg(29, 32'd5, "R10 setup");
    @(negedge clk);
    op_valid = 1; op_code = 5'd14; r1_idx = 5'd29; r2_idx = 5'd29; r3_idx = 5'd29; ls_word = 32'd9;
    #1;
    check(rd_a_data, 32'd5, "R10 old value before edge");
    model[29] = 32'd9;
    expect_reg(29, 32'd9, "R10 new value after edge");

    issue(1, 10, 0, 0, 0, 14'd7, 0, 0); expect_reg(0, 32'd7, "R10 reg0 writable");

    for (int n = 0; n < 3000; n++) begin
      int op;
      op = ($urandom_range(0, 15) == 0) ? 31 : int'($urandom_range(0, 16));
      issue(($urandom_range(0, 7) != 0), op,
            int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
            14'($urandom), $urandom, $urandom);
    end
    for (int i = 0; i < 32; i++) expect_reg(i, model[i], "R10 final sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule